// File: doc/BRIEF.md
# Dual Down-Counter Timer Peripheral

This block is a byte-wide, register-mapped peripheral. It holds two 16-bit down-counters, an interrupt flag and enable pair, and a handful of plain storage bytes. A host reaches it over an 8-bit read/write bus. The register index comes from four address bits starting at bit 9, and the lower address bits are ignored. Both counters step only on cycles where the `tick` input is high. The block therefore runs from any prescaled time base without knowing the clock ratio.

The first counter can run as a free-running periodic source. In that mode it reloads from its 16-bit latch after it passes through zero, and it raises a flag each time it reaches zero. The second counter is a one-shot. Writing its high byte arms it, and it flags once when it steps from 1 to 0. An external `shift_done` pulse sets a third flag source.

A single level output, `irq`, reports any pending and enabled flag on bits 6, 5 or 2. Some reads clear flags as a side effect, and some writes clear flags or load a counter as a side effect. Host software depends on those exact byte accesses.

Top module: `twin_timer_periph`

## Requirements
- R1: After reset, counter one and both latches hold 0xFFFF and counter two holds 0. Register 2 reads 0xFF. The flag and enable registers are 0, so register 14 reads 0x80. All other storage bytes read 0, and `irq` is low.
- R2: The register index is addr[12:9], and addr[8:0] have no effect. Indices 0, 1, 2, 3, 10, 11, 12 and 15 are plain read/write bytes. Indices 1 and 15 are distinct bytes.
- R3: Writing index 5 sets the latch high byte, loads counter one from {written byte, latch low}, and clears flag bit 6. Writing index 4 or 6 changes only the latch low byte. Writing index 7 sets the latch high byte and clears flag bit 6 without loading the counter. Index 4 reads the counter low byte and index 5 the high byte. Indices 6 and 7 read the latch bytes.
- R4: When index 11 bits 7:6 equal 01, counter one counts from its latch value down through 0 to 0xFFFF, then reloads its latch value, giving a period of latch+2 ticks. Flag bit 6 is set on each tick that brings the count to 0.
- R5: With any other value of index 11 bits 7:6, counter one decrements and wraps from 0 to 0xFFFF without reloading, and it never sets flag bit 6.
- R6: A write to index 14 with bit 7 set ORs bits 6:0 into the enables. With bit 7 clear, the write clears every enable bit written as 1. Index 14 reads the enables with bit 7 forced to 1.
- R7: Writing index 13 clears each flag bit written as 1. Reading index 4 clears flag bit 6. Reading index 8 clears flag bit 5. Reading index 10 clears flag bits 4:2.
- R8: Index 13 reads the flags in bits 6:0. Bit 7 reads 1 when any flag is both pending and enabled. `irq` is high exactly when flags AND enables has bit 2, 5 or 6 set.
- R9: Writing index 8 stores the counter-two low byte. Writing index 9 loads counter two from {written byte, stored low byte}, clears flag bit 5 and arms the counter. An armed counter two sets flag bit 5 once when it steps from 1 to 0, then keeps decrementing without flagging again. Indices 8 and 9 read the counter bytes.
- R10: A high `shift_done` on a clock edge sets flag bit 2.
- R11: Neither counter changes on a cycle where `tick` is low, unless it is loaded by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter step enable, one cycle per count |
| shift_done | input | 1 | Pulse that sets flag bit 2 |
| addr | input | 13 | Byte address; bits 12:9 select the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; triggers read side effects |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives counter one across its wrap and reload. It reads the count on the ticks around 0 and 0xFFFF, so an off-by-one period (latch+1 or latch+3) or a missing reload shows up as a wrong count or a misplaced flag. It writes only the latch high byte while a flag is pending, and checks that the counter did not reload while the flag did clear. A design that loads on that write would read a fresh latch value there.

Counter two is ticked well past zero. A design that re-fires would show flag bit 5 pending again after the clearing read. Masked flags are checked against `irq` to catch a design that ignores the enable mask or the 2/5/6 source set. An address with all low bits set catches index decoding taken from the wrong bits.

// File: rtl/twin_timer_pkg.sv
`timescale 1ns/1ps
package twin_timer_pkg;
  localparam int REG_IDX_W = 4;
  localparam int REG_COUNT = 1 << REG_IDX_W;

  // register indices whose position host software decodes
  localparam int IDX_DIR_B   = 2;
  localparam int IDX_T1_LO   = 4;
  localparam int IDX_T1_HI   = 5;
  localparam int IDX_T1L_LO  = 6;
  localparam int IDX_T1L_HI  = 7;
  localparam int IDX_T2_LO   = 8;
  localparam int IDX_T2_HI   = 9;
  localparam int IDX_SHIFT   = 10;
  localparam int IDX_AUX     = 11;
  localparam int IDX_FLAGS   = 13;
  localparam int IDX_ENABLES = 14;

  // storage-only bytes: 0,1,2,3,10,11,12,15
  localparam logic [REG_COUNT-1:0] PLAIN_MASK = 16'b1001_1100_0000_1111;

  // flag bit positions
  localparam int FLAG_SR    = 2;
  localparam int FLAG_SR_HI = 4;
  localparam int FLAG_T2    = 5;
  localparam int FLAG_T1    = 6;

  typedef struct packed {
    logic [REG_COUNT-1:0] wrSel;
    logic                 rdT1Lo;
    logic                 rdT2Lo;
    logic                 rdShift;
  } busStrobe_t;
endpackage

// File: rtl/twin_timer_ctrl.sv
`timescale 1ns/1ps
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [REG_IDX_W-1:0] regIdx,
  output busStrobe_t           strobe
);
  logic readOnly;
  logic unusedAddrBits;

  assign unusedAddrBits = ^addr;
  assign regIdx   = addr[IDX_LSB +: REG_IDX_W];
  // a write on the same cycle suppresses read side effects
  assign readOnly = rd_en & ~wr_en;

  always_comb begin
    strobe.wrSel   = wr_en ? (REG_COUNT'(1) << regIdx) : '0;
    strobe.rdT1Lo  = readOnly && (regIdx == REG_IDX_W'(IDX_T1_LO));
    strobe.rdT2Lo  = readOnly && (regIdx == REG_IDX_W'(IDX_T2_LO));
    strobe.rdShift = readOnly && (regIdx == REG_IDX_W'(IDX_SHIFT));
  end
endmodule

// File: rtl/twin_timer_datapath.sv
`timescale 1ns/1ps
module twin_timer_datapath
  import twin_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 shift_done,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  busStrobe_t           strobe,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irq
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int FLAG_W = DATA_W - 1;
  localparam logic [FLAG_W-1:0] IRQ_SRC =
    FLAG_W'((1 << FLAG_T1) | (1 << FLAG_T2) | (1 << FLAG_SR));

  logic [DATA_W-1:0] plainReg [REG_COUNT];
  logic [FLAG_W-1:0] ifr, ifrNext, ier;
  logic [CNT_W-1:0]  t1Latch, t1Cnt, t1Next, t2Cnt;
  logic [DATA_W-1:0] t2LatchLo;
  logic              t1Cont, t1Fire, t2Armed, t2Fire;

  // storage-only bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++)
        plainReg[i] <= (i == IDX_DIR_B) ? '1 : '0;
    end else begin
      for (int i = 0; i < REG_COUNT; i++)
        if (PLAIN_MASK[i] && strobe.wrSel[i]) plainReg[i] <= wdata;
    end
  end

  assign t1Cont = (plainReg[IDX_AUX][DATA_W-1 -: 2] == 2'b01);

  // counter one: latch -> 0 -> all-ones -> reload when periodic
  always_comb begin
    t1Next = (t1Cont && (t1Cnt == '1)) ? t1Latch : t1Cnt - CNT_W'(1);
    t1Fire = tick && !strobe.wrSel[IDX_T1_HI] && t1Cont && (t1Next == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1Latch <= '1;
      t1Cnt   <= '1;
    end else begin
      if (strobe.wrSel[IDX_T1_LO] || strobe.wrSel[IDX_T1L_LO])
        t1Latch[DATA_W-1:0] <= wdata;
      if (strobe.wrSel[IDX_T1_HI] || strobe.wrSel[IDX_T1L_HI])
        t1Latch[CNT_W-1:DATA_W] <= wdata;
      if (strobe.wrSel[IDX_T1_HI])
        t1Cnt <= {wdata, t1Latch[DATA_W-1:0]};
      else if (tick)
        t1Cnt <= t1Next;
    end
  end

  // counter two: armed one-shot
  assign t2Fire = tick && !strobe.wrSel[IDX_T2_HI] && t2Armed && (t2Cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t2LatchLo <= '1;
      t2Cnt     <= '0;
      t2Armed   <= 1'b0;
    end else begin
      if (strobe.wrSel[IDX_T2_LO]) t2LatchLo <= wdata;
      if (strobe.wrSel[IDX_T2_HI]) begin
        t2Cnt   <= {wdata, t2LatchLo};
        t2Armed <= 1'b1;
      end else if (tick) begin
        t2Cnt <= t2Cnt - CNT_W'(1);
        if (t2Fire) t2Armed <= 1'b0;
      end
    end
  end

  // flags: clears first, new events win
  always_comb begin
    ifrNext = ifr;
    if (strobe.wrSel[IDX_FLAGS]) ifrNext = ifrNext & ~wdata[FLAG_W-1:0];
    if (strobe.wrSel[IDX_T1_HI] || strobe.wrSel[IDX_T1L_HI] || strobe.rdT1Lo)
      ifrNext[FLAG_T1] = 1'b0;
    if (strobe.wrSel[IDX_T2_HI] || strobe.rdT2Lo) ifrNext[FLAG_T2] = 1'b0;
    if (strobe.rdShift) ifrNext[FLAG_SR_HI:FLAG_SR] = '0;
    if (t1Fire)     ifrNext[FLAG_T1] = 1'b1;
    if (t2Fire)     ifrNext[FLAG_T2] = 1'b1;
    if (shift_done) ifrNext[FLAG_SR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifr <= '0;
      ier <= '0;
    end else begin
      ifr <= ifrNext;
      if (strobe.wrSel[IDX_ENABLES]) begin
        if (wdata[DATA_W-1]) ier <= ier | wdata[FLAG_W-1:0];
        else                 ier <= ier & ~wdata[FLAG_W-1:0];
      end
    end
  end

  assign irq = |(ifr & ier & IRQ_SRC);

  always_comb begin
    case (regIdx)
      REG_IDX_W'(IDX_T1_LO):   rdata = t1Cnt[DATA_W-1:0];
      REG_IDX_W'(IDX_T1_HI):   rdata = t1Cnt[CNT_W-1:DATA_W];
      REG_IDX_W'(IDX_T1L_LO):  rdata = t1Latch[DATA_W-1:0];
      REG_IDX_W'(IDX_T1L_HI):  rdata = t1Latch[CNT_W-1:DATA_W];
      REG_IDX_W'(IDX_T2_LO):   rdata = t2Cnt[DATA_W-1:0];
      REG_IDX_W'(IDX_T2_HI):   rdata = t2Cnt[CNT_W-1:DATA_W];
      REG_IDX_W'(IDX_FLAGS):   rdata = {|(ifr & ier), ifr};
      REG_IDX_W'(IDX_ENABLES): rdata = {1'b1, ier};
      default:                 rdata = plainReg[regIdx];
    endcase
  end
endmodule

// File: rtl/twin_timer_periph.sv
`timescale 1ns/1ps
module twin_timer_periph
  import twin_timer_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              shift_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [REG_IDX_W-1:0] regIdx;
  busStrobe_t           strobe;

  twin_timer_ctrl #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_ctrl (
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .regIdx (regIdx),
    .strobe (strobe)
  );

  twin_timer_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .shift_done (shift_done),
    .wdata      (wdata),
    .regIdx     (regIdx),
    .strobe     (strobe),
    .rdata      (rdata),
    .irq        (irq)
  );
endmodule

// File: rtl/twin_timer_chk.sv
`timescale 1ns/1ps
module twin_timer_chk #(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9,
  parameter int DATA_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              shift_done,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq
);
  logic [3:0] idx;
  logic       unusedChkBits;
  assign idx = addr[IDX_LSB +: 4];
  assign unusedChkBits = ^{addr, rdata};

  AST_ENABLE_READ_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && idx == 4'd14) |-> rdata[DATA_W-1]); // R6

  AST_ENABLE_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 4'd14 && wdata == {1'b0, {(DATA_W-1){1'b1}}}) |=> !irq); // R6

  AST_FLAG_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 4'd13 && (&wdata[DATA_W-2:0]) && !tick && !shift_done) |=> !irq); // R7

  AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && idx == 4'd13 && irq) |-> rdata[DATA_W-1]); // R8
endmodule

bind twin_timer_periph twin_timer_chk #(
  .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .shift_done(shift_done),
  .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .rdata(rdata), .irq(irq)
);

// File: tb/twin_timer_periph_bench.sv
`timescale 1ns/1ps
module twin_timer_periph_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        shift_done = 1'b0;
  logic [12:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  twin_timer_periph u_twin_timer_periph (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shift_done(shift_done),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin
    if (rd_en) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected read: actual=%h expected=none", rdata);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wrRaw(input logic [12:0] a, input logic [7:0] v);
    @(posedge clk); #1;
    addr = a; wdata = v; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [7:0] v);
    wrRaw(13'(idx << 9), v);
  endtask

  task automatic rd(input int idx, input logic [7:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(posedge clk); #1;
    addr = 13'(idx << 9); rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1 irq after reset");
    rd(2, 8'hFF, "R1 dir B reset");
    rd(0, 8'h00, "R1 port B reset");
    rd(11, 8'h00, "R1 aux reset");
    rd(4, 8'hFF, "R1 t1 cnt lo");
    rd(5, 8'hFF, "R1 t1 cnt hi");
    rd(6, 8'hFF, "R1 t1 latch lo");
    rd(7, 8'hFF, "R1 t1 latch hi");
    rd(8, 8'h00, "R1 t2 cnt lo");
    rd(13, 8'h00, "R1 flags");
    rd(14, 8'h80, "R1 enables");

    // R9 one-shot counter two
    wr(8, 8'h03);
    wr(9, 8'h00);
    ticks(3);
    rd(13, 8'h20, "R9 t2 fired, masked");
    checkIrq(1'b0, "R8 masked t2");
    wr(14, 8'hA0);
    checkIrq(1'b1, "R8 enabled t2");
    rd(13, 8'hA0, "R8 summary bit");
    rd(14, 8'hA0, "R6 enable readback");
    ticks(2);
    rd(9, 8'hFF, "R9 t2 wraps hi");
    rd(8, 8'hFE, "R9 t2 wraps lo");
    rd(13, 8'h00, "R7 t2 flag cleared by read, R9 no refire");
    checkIrq(1'b0, "R7 irq after t2 read");

    // R4 periodic counter one, latch 2 -> period 4
    wr(11, 8'h40);
    wr(4, 8'h02);
    wr(5, 8'h00);
    wr(14, 8'hC0);
    ticks(2);
    rd(13, 8'hC0, "R4 t1 reaches zero");
    checkIrq(1'b1, "R8 t1 irq");
    wr(13, 8'h40);
    checkIrq(1'b0, "R7 flag write clear");
    ticks(3);
    rd(4, 8'h01, "R4 reload after all-ones");
    rd(5, 8'h00, "R4 cnt hi after reload");
    rd(13, 8'h00, "R4 no early flag");
    ticks(1);
    rd(13, 8'hC0, "R4 period latch+2");
    rd(4, 8'h00, "R7 t1 lo read");
    rd(13, 8'h00, "R7 t1 flag cleared by read");

    // R3 latch-high write clears without load
    ticks(4);
    checkIrq(1'b1, "R4 second period flag");
    wr(7, 8'h01);
    checkIrq(1'b0, "R3 latch hi write clears flag");
    rd(13, 8'h00, "R3 flag clear");
    rd(4, 8'h00, "R3 no load on latch hi");
    repeat (5) @(posedge clk);
    rd(5, 8'h00, "R11 no change without tick");
    rd(6, 8'h02, "R3 latch lo");
    rd(7, 8'h01, "R3 latch hi");
    wr(6, 8'h05);
    rd(4, 8'h00, "R3 latch lo write no load");
    rd(6, 8'h05, "R3 latch lo updated");

    // R5 non-periodic mode
    wr(11, 8'h00);
    wr(5, 8'h00);
    ticks(7);
    rd(13, 8'h00, "R5 no flag in one-shot mode");
    rd(4, 8'hFE, "R5 wrap lo");
    rd(5, 8'hFF, "R5 wrap hi");

    // R6 enable clear
    wr(14, 8'h20);
    rd(14, 8'hC0, "R6 enable clear");

    // R10 shift flag, R7 shift read clear
    @(posedge clk); #1 shift_done = 1'b1;
    @(posedge clk); #1 shift_done = 1'b0;
    checkIrq(1'b0, "R8 shift masked");
    rd(13, 8'h04, "R10 shift flag set");
    wr(14, 8'h84);
    checkIrq(1'b1, "R8 shift enabled");
    rd(13, 8'h84, "R8 summary with shift");
    rd(10, 8'h00, "R7 shift read");
    rd(13, 8'h00, "R7 shift flag cleared");
    checkIrq(1'b0, "R7 irq after shift read");

    // R2 storage bytes and index decode
    wr(0, 8'h5A);
    wr(1, 8'h3C);
    wr(15, 8'hC3);
    wr(12, 8'h77);
    wr(3, 8'hA5);
    wrRaw(13'h15FF, 8'h11);
    rd(0, 8'h5A, "R2 port B");
    rd(1, 8'h3C, "R2 port A distinct");
    rd(15, 8'hC3, "R2 port A alt distinct");
    rd(12, 8'h77, "R2 periph ctrl");
    rd(3, 8'hA5, "R2 dir A");
    rd(10, 8'h11, "R2 low addr bits ignored");

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule